// File: doc/BRIEF.md
# One-of-Four Link Codec

This block carries a parallel word over a long bundle of wires without a shared timing reference at the far end. The transmit half splits the word into bit pairs. Each pair goes out on four rails, and exactly one of the four is pulled low to carry the pair's value. When the send request is low, every rail rests high; this all-high state is the empty spacer.

The receive half watches the rails group by group. It declares the word present only once every group holds a legal codeword. It withdraws that declaration only after every group has gone back to empty. Between those two points it holds its state, in the way a Muller C-element does. The receive data-valid output therefore serves as the acknowledge of a four-phase return-to-zero handshake: request rises, acknowledge rises, request falls, acknowledge falls.

The rail bundle leaves the block on one port and comes back in on another. The wires, and any repeaters on them, sit outside the block. The design is synchronous, and its registers model the levels of the handshake signals.

Top module: `quad_rail_link`

## Requirements
- R1: During and right after reset, every bit of `tx_rails` is 1, `rx_valid` is 0, `rx_err` is 0 and `rx_data` is 0.
- R2: While `tx_req` is high at a clock edge, after that edge group g of `tx_rails` (bits 4g+3..4g) has bit 4g+v low and its other three bits high, where v is `tx_data[2g+1:2g]`.
- R3: While `tx_req` is low at a clock edge, after that edge every bit of `tx_rails` is 1.
- R4: When every group of `rx_rails` holds exactly one low rail at a clock edge and `rx_valid` is 0, `rx_valid` becomes 1 after that edge. In the same edge `rx_data[2g+1:2g]` takes the index of the low rail in group g.
- R5: Once high, `rx_valid` stays high while any group still holds a codeword. It falls at the first edge at which every bit of `rx_rails` is 1.
- R6: While one or more groups of `rx_rails` are still all-high, `rx_valid` does not rise, even if the other groups hold codewords.
- R7: If any group of `rx_rails` has two or more low rails at a clock edge, `rx_err` is 1 after that edge and `rx_valid` does not rise at that edge. `rx_err` returns to 0 after an edge with no such group.
- R8: `rx_data` does not change while `rx_valid` stays high.
- R9: The completion and release detection gives the same results when the group count exceeds eight as when it does not. In the larger case the reduction is built as a two-level tree of gates with no more than eight inputs each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_req | input | 1 | Send request; `tx_data` must stay steady while it is high |
| tx_data | input | WIDTH | Word to send |
| tx_rails | output | 2*WIDTH | Active-low one-of-four rails toward the wire bundle |
| rx_rails | input | 2*WIDTH | Rails arriving from the wire bundle |
| rx_data | output | WIDTH | Decoded word, held while `rx_valid` is high |
| rx_valid | output | 1 | Data-valid, which is also the handshake acknowledge |
| rx_err | output | 1 | Some group carried more than one low rail |

## Verification
The bench builds two instances. The first has a 20-bit word, which gives ten groups and so uses the two-level reduction tree with a partly padded second chunk. The second has a 4-bit word, whose two groups take the flat single-gate path. The rails of each instance are normally looped back. A bench-driven override can replace them on the wide instance, which lets the tests present partial arrival, staggered release and groups with two low rails. The encoder alone can never produce those cases.

// File: rtl/qrl_pkg.sv
package qrl_pkg;
   localparam int RAILS_PER_GROUP = 4;
   localparam int BITS_PER_GROUP  = 2;

   // Active-low one-of-four code: rail number v is driven low.
   function automatic logic [3:0] pair_to_rails(input logic [1:0] pair);
      return ~(4'b0001 << pair);
   endfunction

   // Index of the low rail, assuming exactly one is low.
   function automatic logic [1:0] rails_to_pair(input logic [3:0] rails);
      logic [3:0] act;
      act = ~rails;
      return {act[3] | act[2], act[3] | act[1]};
   endfunction
endpackage

// File: rtl/qrl_reduce.sv
module qrl_reduce #(
   parameter int N      = 4,
   parameter int FANIN  = 8,
   parameter bit IS_AND = 1'b1
) (
   input  logic [N-1:0] din,
   output logic         dout
);
   localparam logic IDENT  = IS_AND;
   localparam int   CHUNKS = (N + FANIN - 1) / FANIN;

   if (N < 1 || FANIN < 2) begin : g_bad_cfg
      $error("qrl_reduce: N must be at least 1 and FANIN at least 2");
   end
   if (CHUNKS > FANIN) begin : g_too_wide
      $error("qrl_reduce: N exceeds FANIN*FANIN");
   end

   if (N <= FANIN) begin : g_flat
      assign dout = IS_AND ? (&din) : (|din);
   end else begin : g_tree
      logic [CHUNKS*FANIN-1:0] padded;
      logic [CHUNKS-1:0]       partial;

      always_comb begin
         padded        = {(CHUNKS*FANIN){IDENT}};
         padded[N-1:0] = din;
      end

      for (genvar c = 0; c < CHUNKS; c++) begin : g_leaf
         assign partial[c] = IS_AND ? (&padded[c*FANIN +: FANIN])
                                    : (|padded[c*FANIN +: FANIN]);
      end

      assign dout = IS_AND ? (&partial) : (|partial);
   end
endmodule

// File: rtl/qrl_celem.sv
module qrl_celem #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] din,
   output logic         dout
);
   always_ff @(posedge clk) begin
      if (rst)            dout <= 1'b0;
      else if (&din)      dout <= 1'b1;
      else if (~|din)     dout <= 1'b0;
   end
endmodule

// File: rtl/qrl_encoder.sv
module qrl_encoder #(
   parameter int WIDTH = 20
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               req,
   input  logic [WIDTH-1:0]   data,
   output logic [2*WIDTH-1:0] rails
);
   import qrl_pkg::*;
   localparam int GROUPS = WIDTH / BITS_PER_GROUP;

   logic [2*WIDTH-1:0] code;

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      assign code[g*RAILS_PER_GROUP +: RAILS_PER_GROUP] =
         pair_to_rails(data[g*BITS_PER_GROUP +: BITS_PER_GROUP]);
   end

   always_ff @(posedge clk) begin
      if (rst)      rails <= '1;
      else if (req) rails <= code;
      else          rails <= '1;
   end

   // Each group on the wire is either empty or carries one low rail.
   logic legal_out;
   always_comb begin
      legal_out = 1'b1;
      for (int g = 0; g < GROUPS; g++)
         if (!$onehot0(~rails[g*4 +: 4])) legal_out = 1'b0;
   end

   assert_legal_code_R2: assert property (@(posedge clk) disable iff (rst)
      legal_out);
   assert_spacer_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
      !req |=> (rails == '1));
endmodule

// File: rtl/qrl_decoder.sv
module qrl_decoder #(
   parameter int WIDTH = 20,
   parameter int FANIN = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [2*WIDTH-1:0] rails,
   output logic [WIDTH-1:0]   data,
   output logic               valid,
   output logic               err
);
   import qrl_pkg::*;
   localparam int GROUPS = WIDTH / BITS_PER_GROUP;

   logic [GROUPS-1:0] grp_valid, grp_empty, grp_multi;
   logic [WIDTH-1:0]  decoded;
   logic              all_valid, all_empty, any_multi, complete;

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      logic [3:0] act;
      assign act          = ~rails[g*RAILS_PER_GROUP +: RAILS_PER_GROUP];
      assign grp_valid[g] = |act;
      assign grp_empty[g] = ~grp_valid[g];
      assign grp_multi[g] = (act[0] & act[1]) | (act[0] & act[2]) | (act[0] & act[3])
                          | (act[1] & act[2]) | (act[1] & act[3]) | (act[2] & act[3]);
      assign decoded[g*BITS_PER_GROUP +: BITS_PER_GROUP] =
         rails_to_pair(rails[g*RAILS_PER_GROUP +: RAILS_PER_GROUP]);
   end

   qrl_reduce #(.N(GROUPS), .FANIN(FANIN), .IS_AND(1'b1)) u_all_valid (
      .din(grp_valid), .dout(all_valid));
   qrl_reduce #(.N(GROUPS), .FANIN(FANIN), .IS_AND(1'b1)) u_all_empty (
      .din(grp_empty), .dout(all_empty));
   qrl_reduce #(.N(GROUPS), .FANIN(FANIN), .IS_AND(1'b0)) u_any_multi (
      .din(grp_multi), .dout(any_multi));

   assign complete = all_valid & ~any_multi;

   qrl_celem #(.N(2)) u_hold (
      .clk (clk),
      .rst (rst),
      .din ({complete, ~all_empty}),
      .dout(valid)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         data <= '0;
         err  <= 1'b0;
      end else begin
         err <= any_multi;
         if (complete && !valid) data <= decoded;
      end
   end

   // Independent per-group check built straight from the rails.
   logic chk_all_onehot, chk_all_high;
   always_comb begin
      chk_all_onehot = 1'b1;
      for (int g = 0; g < GROUPS; g++)
         if ($countones(~rails[g*4 +: 4]) != 1) chk_all_onehot = 1'b0;
      chk_all_high = (rails == '1);
   end

   assert_rise_needs_full_word_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(valid) |-> $past(chk_all_onehot));
   assert_fall_needs_all_empty_R5: assert property (@(posedge clk) disable iff (rst)
      $fell(valid) |-> $past(chk_all_high));
   assert_no_rise_on_error_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(valid) |-> !err);
   assert_data_held_R8: assert property (@(posedge clk) disable iff (rst)
      (valid && $past(valid)) |-> $stable(data));
endmodule

// File: rtl/quad_rail_link.sv
module quad_rail_link #(
   parameter int WIDTH = 20,
   parameter int FANIN = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tx_req,
   input  logic [WIDTH-1:0]   tx_data,
   output logic [2*WIDTH-1:0] tx_rails,
   input  logic [2*WIDTH-1:0] rx_rails,
   output logic [WIDTH-1:0]   rx_data,
   output logic               rx_valid,
   output logic               rx_err
);
   if (WIDTH < 2 || (WIDTH % 2) != 0) begin : g_bad_width
      $error("quad_rail_link: WIDTH must be even and at least 2");
   end

   qrl_encoder #(.WIDTH(WIDTH)) u_enc (
      .clk  (clk),
      .rst  (rst),
      .req  (tx_req),
      .data (tx_data),
      .rails(tx_rails)
   );

   qrl_decoder #(.WIDTH(WIDTH), .FANIN(FANIN)) u_dec (
      .clk  (clk),
      .rst  (rst),
      .rails(rx_rails),
      .data (rx_data),
      .valid(rx_valid),
      .err  (rx_err)
   );
endmodule

// File: tb/quad_rail_link_test.sv
module quad_rail_link_test;
   localparam int W  = 20;
   localparam int WS = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   logic           tx_req = 1'b0;
   logic [W-1:0]   tx_data = '0;
   logic [2*W-1:0] tx_rails, rx_rails, inj_rails = '1;
   logic           inj_en = 1'b0;
   logic [W-1:0]   rx_data;
   logic           rx_valid, rx_err;

   assign rx_rails = inj_en ? inj_rails : tx_rails;

   quad_rail_link #(.WIDTH(W)) uut (
      .clk(clk), .rst(rst), .tx_req(tx_req), .tx_data(tx_data),
      .tx_rails(tx_rails), .rx_rails(rx_rails), .rx_data(rx_data),
      .rx_valid(rx_valid), .rx_err(rx_err));

   logic            s_req = 1'b0;
   logic [WS-1:0]   s_data = '0;
   logic [2*WS-1:0] s_rails;
   logic [WS-1:0]   s_rx_data;
   logic            s_valid, s_err;

   quad_rail_link #(.WIDTH(WS)) uut_small (
      .clk(clk), .rst(rst), .tx_req(s_req), .tx_data(s_data),
      .tx_rails(s_rails), .rx_rails(s_rails), .rx_data(s_rx_data),
      .rx_valid(s_valid), .rx_err(s_err));

   function automatic logic [2*W-1:0] enc(input logic [W-1:0] d, input int groups);
      logic [2*W-1:0] r;
      r = '1;
      for (int g = 0; g < groups; g++) r[4*g + d[2*g +: 2]] = 1'b0;
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      check(tx_rails == '1, "R1 rails", 64'(tx_rails), 64'hFF_FFFF_FFFF);
      check(rx_valid == 1'b0, "R1 valid", 64'(rx_valid), 0);
      check(rx_err == 1'b0, "R1 err", 64'(rx_err), 0);
      check(rx_data == '0, "R1 data", 64'(rx_data), 0);
   endtask

   task automatic t_word(input logic [W-1:0] d);
      tx_data = d;
      tx_req  = 1'b1;
      step();
      check(tx_rails == enc(d, W/2), "R2 encode", 64'(tx_rails), 64'(enc(d, W/2)));
      check(rx_valid == 1'b0, "R4 not yet", 64'(rx_valid), 0);
      step();
      check(rx_valid == 1'b1, "R4 valid", 64'(rx_valid), 1);
      check(rx_data == d, "R4 data", 64'(rx_data), 64'(d));
      tx_req = 1'b0;
      step();
      check(tx_rails == '1, "R3 spacer", 64'(tx_rails), 64'hFF_FFFF_FFFF);
      check(rx_valid == 1'b1 && rx_data == d, "R8 held", 64'(rx_data), 64'(d));
      step();
      check(rx_valid == 1'b0, "R5 release", 64'(rx_valid), 0);
   endtask

   task automatic t_partial();
      logic [W-1:0]   d;
      logic [2*W-1:0] full;
      d    = 20'h9C3A5;
      full = enc(d, W/2);
      inj_en = 1'b1;
      inj_rails = '1;
      inj_rails[23:0] = full[23:0];
      step();
      step();
      check(rx_valid == 1'b0, "R6 partial arrival", 64'(rx_valid), 0);
      inj_rails = full;
      step();
      check(rx_valid == 1'b1 && rx_data == d, "R4 late group", 64'(rx_data), 64'(d));
      inj_rails[15:0] = '1;
      step();
      step();
      check(rx_valid == 1'b1, "R5 partial release", 64'(rx_valid), 1);
      check(rx_data == d, "R8 held during release", 64'(rx_data), 64'(d));
      inj_rails = '1;
      step();
      check(rx_valid == 1'b0, "R5 all empty", 64'(rx_valid), 0);
      inj_en = 1'b0;
   endtask

   task automatic t_illegal();
      logic [2*W-1:0] bad;
      bad = enc(20'h12345, W/2);
      bad[4*7 +: 4] = 4'b1010;
      inj_en = 1'b1;
      inj_rails = bad;
      step();
      check(rx_err == 1'b1, "R7 err", 64'(rx_err), 1);
      check(rx_valid == 1'b0, "R7 no valid", 64'(rx_valid), 0);
      inj_rails = '1;
      step();
      check(rx_err == 1'b0, "R7 err clears", 64'(rx_err), 0);
      inj_en = 1'b0;
   endtask

   task automatic t_small(input logic [WS-1:0] d);
      s_data = d;
      s_req  = 1'b1;
      step();
      check(s_rails == enc(W'(d), WS/2)[2*WS-1:0], "R9 small encode",
            64'(s_rails), 64'(enc(W'(d), WS/2)));
      step();
      check(s_valid && s_rx_data == d, "R9 small valid", 64'(s_rx_data), 64'(d));
      s_req = 1'b0;
      step();
      step();
      check(s_valid == 1'b0, "R9 small release", 64'(s_valid), 0);
   endtask

   initial begin
      @(negedge clk);
      step();
      t_reset();
      rst = 1'b0;
      step();
      t_reset();
      t_word(20'h00000);
      t_word(20'hFFFFF);
      t_word(20'hA5C39);
      t_word(20'h1B2E4);
      t_partial();
      t_illegal();
      t_word(20'h6D071);
      t_small(4'h0);
      t_small(4'hB);
      t_small(4'h6);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule